// File: doc/BRIEF.md
# SIMD Condition Flag Unit

This block holds the negative, zero and carry flags of a sixteen-lane SIMD datapath and turns them into control decisions. Each lane has its own flag triple. When an instruction asks for a flag update, the unit takes new flag values from the add pipe's lane results. If the add pipe is idle for that instruction, it takes them from the multiply pipe's lane results instead. The add pipe counts as idle when its opcode is a NOP or its write condition is NEVER.

In the same cycle, the unit evaluates two things against the flags held before this instruction's update. The first is a write condition for each pipe, which gives a per-lane write enable for that pipe's result. The second is a branch condition, which reduces all lanes to one taken bit with "every lane" or "at least one lane" semantics. Any flag update lands on the next rising clock edge. Lane count and lane width are parameters.

Top module: `simd_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears every N, Z and C flag of every lane.
- R2: While `set_flags` is low, no flag changes at a clock edge.
- R3: With `set_flags` high, `add_nop` low and `add_wcond` not 0, each lane's flags are loaded from the add pipe's lane result and carry.
- R4: With `set_flags` high and `add_nop` high, each lane's flags are loaded from the multiply pipe's lane result and carry.
- R5: With `set_flags` high and `add_wcond` equal to 0 (NEVER), each lane's flags are loaded from the multiply pipe, even when `add_nop` is low.
- R6: Write condition codes per lane: 0 never, 1 always, 2 Z set, 3 Z clear, 4 N set, 5 N clear, 6 C set, 7 C clear. Bit i of `add_wen` or `mul_wen` is the result for lane i.
- R7: Write enables and the branch result are combinational from the flags held before the current cycle's update. A new flag value is first visible in the cycle after the clock edge that loads it.
- R8: Branch codes 0 to 11 mean: 0 all Z set, 1 all Z clear, 2 any Z set, 3 any Z clear. Codes 4 to 7 follow the same pattern for N, and codes 8 to 11 follow it for C.
- R9: Branch code 15 is always taken. Codes 12, 13 and 14 are never taken.
- R10: A lane's N flag is bit 31 of its 32-bit result. Its Z flag is set exactly when that result is zero. Its C flag is the lane carry input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_flags | input | 1 | Instruction requests a flag update |
| add_nop | input | 1 | Add pipe opcode is a NOP |
| add_wcond | input | 3 | Add pipe write condition |
| mul_wcond | input | 3 | Multiply pipe write condition |
| br_cond | input | 4 | Branch condition code |
| add_res | input | LANES*DW | Add pipe lane results, lane i at bits i*DW upward |
| add_cy | input | LANES | Add pipe lane carries |
| mul_res | input | LANES*DW | Multiply pipe lane results |
| mul_cy | input | LANES | Multiply pipe lane carries |
| add_wen | output | LANES | Add pipe per-lane write enable |
| mul_wen | output | LANES | Multiply pipe per-lane write enable |
| br_taken | output | 1 | Branch condition met |

## Verification
The bench drives the fallback cases directly. An add-NOP with flags requested must load flags from the multiply pipe, and so must an add condition of NEVER. A design that keyed only on the opcode would load add-pipe flags in the NEVER case. It also checks lanes whose results are zero, have bit 31 set, or differ in carry. A wrong Z or N derivation then shows up in the write enables and branch results of the following cycle. A design that let the new flags leak into the current cycle's enables would mismatch the reference model on every flag-setting instruction. The all/any polarities and the reserved branch codes are swept with mixed lane patterns, so a swapped reduction or a taken reserved code is exposed.

// File: rtl/simd_flag_pkg.sv
package simd_flag_pkg;
   typedef enum logic [2:0] {
      WC_NEVER  = 3'd0,
      WC_ALWAYS = 3'd1,
      WC_ZSET   = 3'd2,
      WC_ZCLR   = 3'd3,
      WC_NSET   = 3'd4,
      WC_NCLR   = 3'd5,
      WC_CSET   = 3'd6,
      WC_CCLR   = 3'd7
   } wcond_e;

   // branch code groups, selected by the two upper code bits
   localparam logic [1:0] BG_ZERO  = 2'd0;
   localparam logic [1:0] BG_NEG   = 2'd1;
   localparam logic [1:0] BG_CARRY = 2'd2;
   localparam logic [1:0] BG_SPEC  = 2'd3;
   localparam logic [3:0] BR_UNCOND = 4'd15;
endpackage

// File: rtl/flag_src_sel.sv
module flag_src_sel
   import simd_flag_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 32
) (
   input  logic                  add_nop,
   input  wcond_e                add_wcond,
   input  logic [LANES*DW-1:0]   add_res,
   input  logic [LANES-1:0]      add_cy,
   input  logic [LANES*DW-1:0]   mul_res,
   input  logic [LANES-1:0]      mul_cy,
   output logic [LANES-1:0]      nxt_n,
   output logic [LANES-1:0]      nxt_z,
   output logic [LANES-1:0]      nxt_c
);
   localparam int SIGN_BIT = DW - 1;

   if (DW < 2) begin : g_bad_dw
      $error("flag_src_sel: DW must be at least 2");
   end

   logic take_mul;
   assign take_mul = add_nop | (add_wcond == WC_NEVER);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [DW-1:0] val;
      assign val       = take_mul ? mul_res[ln*DW +: DW] : add_res[ln*DW +: DW];
      assign nxt_n[ln] = val[SIGN_BIT];
      assign nxt_z[ln] = (val == '0);
      assign nxt_c[ln] = take_mul ? mul_cy[ln] : add_cy[ln];
   end
endmodule

// File: rtl/lane_cond_eval.sv
module lane_cond_eval
   import simd_flag_pkg::*;
#(
   parameter int LANES = 16
) (
   input  wcond_e             cond,
   input  logic [LANES-1:0]   fl_n,
   input  logic [LANES-1:0]   fl_z,
   input  logic [LANES-1:0]   fl_c,
   output logic [LANES-1:0]   wen
);
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_comb begin
         unique case (cond)
            WC_NEVER:  wen[ln] = 1'b0;
            WC_ALWAYS: wen[ln] = 1'b1;
            WC_ZSET:   wen[ln] = fl_z[ln];
            WC_ZCLR:   wen[ln] = ~fl_z[ln];
            WC_NSET:   wen[ln] = fl_n[ln];
            WC_NCLR:   wen[ln] = ~fl_n[ln];
            WC_CSET:   wen[ln] = fl_c[ln];
            WC_CCLR:   wen[ln] = ~fl_c[ln];
            default:   wen[ln] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/branch_reduce.sv
module branch_reduce
   import simd_flag_pkg::*;
#(
   parameter int LANES = 16
) (
   input  logic [3:0]         br_cond,
   input  logic [LANES-1:0]   fl_n,
   input  logic [LANES-1:0]   fl_z,
   input  logic [LANES-1:0]   fl_c,
   output logic               taken
);
   logic [LANES-1:0] pick;
   logic [LANES-1:0] polar;
   logic             reduced;

   always_comb begin
      unique case (br_cond[3:2])
         BG_ZERO:  pick = fl_z;
         BG_NEG:   pick = fl_n;
         BG_CARRY: pick = fl_c;
         default:  pick = '0;
      endcase
      polar   = br_cond[0] ? ~pick : pick;
      reduced = br_cond[1] ? (|polar) : (&polar);
      taken   = (br_cond[3:2] == BG_SPEC) ? (br_cond == BR_UNCOND) : reduced;
   end
endmodule

// File: rtl/simd_flag_unit.sv
module simd_flag_unit
   import simd_flag_pkg::*;
#(
   parameter int LANES = 16,
   parameter int DW    = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  set_flags,
   input  logic                  add_nop,
   input  logic [2:0]            add_wcond,
   input  logic [2:0]            mul_wcond,
   input  logic [3:0]            br_cond,
   input  logic [LANES*DW-1:0]   add_res,
   input  logic [LANES-1:0]      add_cy,
   input  logic [LANES*DW-1:0]   mul_res,
   input  logic [LANES-1:0]      mul_cy,
   output logic [LANES-1:0]      add_wen,
   output logic [LANES-1:0]      mul_wen,
   output logic                  br_taken
);
   if (LANES < 1) begin : g_bad_lanes
      $error("simd_flag_unit: LANES must be positive");
   end

   logic [LANES-1:0] n_q, z_q, c_q;
   logic [LANES-1:0] n_d, z_d, c_d;

   flag_src_sel #(.LANES(LANES), .DW(DW)) src_i (
      .add_nop   (add_nop),
      .add_wcond (wcond_e'(add_wcond)),
      .add_res   (add_res),
      .add_cy    (add_cy),
      .mul_res   (mul_res),
      .mul_cy    (mul_cy),
      .nxt_n     (n_d),
      .nxt_z     (z_d),
      .nxt_c     (c_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         n_q <= '0;
         z_q <= '0;
         c_q <= '0;
      end else if (set_flags) begin
         n_q <= n_d;
         z_q <= z_d;
         c_q <= c_d;
      end
   end

   lane_cond_eval #(.LANES(LANES)) add_ev_i (
      .cond (wcond_e'(add_wcond)),
      .fl_n (n_q),
      .fl_z (z_q),
      .fl_c (c_q),
      .wen  (add_wen)
   );

   lane_cond_eval #(.LANES(LANES)) mul_ev_i (
      .cond (wcond_e'(mul_wcond)),
      .fl_n (n_q),
      .fl_z (z_q),
      .fl_c (c_q),
      .wen  (mul_wen)
   );

   branch_reduce #(.LANES(LANES)) br_i (
      .br_cond (br_cond),
      .fl_n    (n_q),
      .fl_z    (z_q),
      .fl_c    (c_q),
      .taken   (br_taken)
   );
endmodule

// File: rtl/simd_flag_chk.sv
module simd_flag_chk #(
   parameter int LANES = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               set_flags,
   input logic [2:0]         add_wcond,
   input logic [2:0]         mul_wcond,
   input logic [3:0]         br_cond,
   input logic [LANES-1:0]   add_wen,
   input logic [LANES-1:0]   mul_wen,
   input logic               br_taken,
   input logic [LANES-1:0]   fl_n,
   input logic [LANES-1:0]   fl_z,
   input logic [LANES-1:0]   fl_c
);
   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   // R1
   always_ff @(posedge clk) begin
      if (rst_d) begin
         reset_clears_chk: assert ({fl_n, fl_z, fl_c} == '0);
      end
   end

   // R2
   hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
      !set_flags |=> $stable({fl_n, fl_z, fl_c}));

   // R6
   never_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      (add_wcond == 3'd0) |-> (add_wen == '0));

   // R6
   always_opens_chk: assert property (@(posedge clk) disable iff (rst)
      (mul_wcond == 3'd1) |-> (mul_wen == '1));

   // R6
   zset_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (add_wcond == 3'd2) |-> (add_wen == fl_z));

   // R8
   any_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (br_cond == 4'd2) |-> (br_taken == (|fl_z)));

   // R8
   all_carry_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (br_cond == 4'd9) |-> (br_taken == ~(|fl_c)));

   // R9
   br_uncond_chk: assert property (@(posedge clk) disable iff (rst)
      (br_cond == 4'd15) |-> br_taken);

   // R9
   br_reserved_chk: assert property (@(posedge clk) disable iff (rst)
      (br_cond >= 4'd12 && br_cond <= 4'd14) |-> !br_taken);
endmodule

bind simd_flag_unit simd_flag_chk #(.LANES(LANES)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .set_flags (set_flags),
   .add_wcond (add_wcond),
   .mul_wcond (mul_wcond),
   .br_cond   (br_cond),
   .add_wen   (add_wen),
   .mul_wen   (mul_wen),
   .br_taken  (br_taken),
   .fl_n      (n_q),
   .fl_z      (z_q),
   .fl_c      (c_q)
);

// File: tb/simd_flag_unit_tb_top.sv
`timescale 1ns/1ps
module simd_flag_unit_tb_top;
   localparam int LANES = 16;
   localparam int DW    = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                rst = 1'b1;
   logic                set_flags = 1'b0;
   logic                add_nop = 1'b0;
   logic [2:0]          add_wcond = 3'd0;
   logic [2:0]          mul_wcond = 3'd0;
   logic [3:0]          br_cond = 4'd0;
   logic [LANES*DW-1:0] add_res = '0;
   logic [LANES-1:0]    add_cy = '0;
   logic [LANES*DW-1:0] mul_res = '0;
   logic [LANES-1:0]    mul_cy = '0;
   logic [LANES-1:0]    add_wen, mul_wen;
   logic                br_taken;

   simd_flag_unit #(.LANES(LANES), .DW(DW)) dut_i (
      .clk(clk), .rst(rst), .set_flags(set_flags), .add_nop(add_nop),
      .add_wcond(add_wcond), .mul_wcond(mul_wcond), .br_cond(br_cond),
      .add_res(add_res), .add_cy(add_cy), .mul_res(mul_res), .mul_cy(mul_cy),
      .add_wen(add_wen), .mul_wen(mul_wen), .br_taken(br_taken)
   );

   // reference flags
   bit [LANES-1:0] m_n, m_z, m_c;
   int n_cmp = 0;
   int n_bad = 0;

   function automatic bit lane_ok(int cd, bit n, bit z, bit c);
      case (cd)
         0: return 1'b0;
         1: return 1'b1;
         2: return z;
         3: return !z;
         4: return n;
         5: return !n;
         6: return c;
         default: return !c;
      endcase
   endfunction

   function automatic bit branch_ok(int cd);
      bit [LANES-1:0] f;
      int hits;
      if (cd == 15) return 1'b1;
      if (cd >= 12) return 1'b0;
      f = (cd < 4) ? m_z : (cd < 8) ? m_n : m_c;
      hits = 0;
      for (int i = 0; i < LANES; i++) if (f[i] != cd[0]) hits++;
      return cd[1] ? (hits > 0) : (hits == LANES);
   endfunction

   function automatic logic [DW-1:0] pick_val();
      case ($urandom % 4)
         0: return '0;
         1: return {1'b1, 31'($urandom)};
         default: return DW'($urandom);
      endcase
   endfunction

   task automatic check(string tag, string what, logic [LANES-1:0] got, logic [LANES-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   // inputs are set just after a falling edge; compare, then advance
   task automatic run_cycle(string tag, bit do_cmp);
      logic [LANES-1:0] ea, em;
      bit use_mul;
      #1;
      if (do_cmp) begin
         for (int i = 0; i < LANES; i++) begin
            ea[i] = lane_ok(int'(add_wcond), m_n[i], m_z[i], m_c[i]);
            em[i] = lane_ok(int'(mul_wcond), m_n[i], m_z[i], m_c[i]);
         end
         check(tag, "add_wen", add_wen, ea);
         check(tag, "mul_wen", mul_wen, em);
         check((br_cond >= 4'd12) ? "R9" : tag, "br_taken",
               {{(LANES-1){1'b0}}, br_taken}, {{(LANES-1){1'b0}}, branch_ok(int'(br_cond))});
      end
      @(posedge clk);
      if (rst) begin
         m_n = '0; m_z = '0; m_c = '0;
      end else if (set_flags) begin
         use_mul = add_nop || (add_wcond == 3'd0);
         for (int i = 0; i < LANES; i++) begin
            logic [DW-1:0] v;
            v = use_mul ? mul_res[i*DW +: DW] : add_res[i*DW +: DW];
            m_n[i] = v[DW-1];
            m_z[i] = (v == '0);
            m_c[i] = use_mul ? mul_cy[i] : add_cy[i];
         end
      end
      @(negedge clk);
   endtask

   task automatic fill_random();
      for (int i = 0; i < LANES; i++) begin
         add_res[i*DW +: DW] = pick_val();
         mul_res[i*DW +: DW] = pick_val();
      end
      add_cy = LANES'($urandom);
      mul_cy = LANES'($urandom);
   endtask

   task automatic probe(string tag);
      // read back every flag through conditions and branches
      for (int cd = 2; cd < 8; cd++) begin
         set_flags = 1'b0;
         add_wcond = 3'(cd);
         mul_wcond = 3'(cd ^ 1);
         br_cond   = 4'((cd - 2) * 2);
         run_cycle(tag, 1'b1);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      rst = 1'b1;
      run_cycle("R1", 1'b0);
      run_cycle("R1", 1'b0);
      rst = 1'b0;
      // R1: after reset all flags are clear
      br_cond = 4'd1; add_wcond = 3'd3; mul_wcond = 3'd7;
      run_cycle("R1", 1'b1);
      probe("R1");

      // R10 / R3: add pipe source with crafted lanes
      fill_random();
      add_res[0*DW +: DW] = '0;
      add_res[1*DW +: DW] = 32'h8000_0000;
      add_res[2*DW +: DW] = 32'h0000_0001;
      add_res[3*DW +: DW] = 32'hFFFF_FFFF;
      set_flags = 1'b1; add_nop = 1'b0; add_wcond = 3'd2; mul_wcond = 3'd4;
      br_cond = 4'd2;
      run_cycle("R7", 1'b1);   // R7: enables still see the old flags
      probe("R10");
      probe("R3");

      // R4: add NOP falls back to the multiply pipe
      fill_random();
      set_flags = 1'b1; add_nop = 1'b1; add_wcond = 3'd1;
      run_cycle("R4", 1'b1);
      add_nop = 1'b0;
      probe("R4");

      // R5: NEVER on the add pipe also falls back
      fill_random();
      set_flags = 1'b1; add_nop = 1'b0; add_wcond = 3'd0;
      run_cycle("R5", 1'b1);
      probe("R5");

      // R2: flags hold while set_flags is low
      for (int k = 0; k < 4; k++) begin
         fill_random();
         set_flags = 1'b0; add_wcond = 3'd1; br_cond = 4'(k);
         run_cycle("R2", 1'b1);
      end
      probe("R2");

      // R9: every branch code including reserved ones
      for (int cd = 0; cd < 16; cd++) begin
         set_flags = 1'b0; br_cond = 4'(cd);
         run_cycle((cd >= 12) ? "R9" : "R8", 1'b1);
      end

      // R6 / R8: random mix
      for (int k = 0; k < 400; k++) begin
         fill_random();
         if (k % 25 == 0) begin
            add_cy = '1; mul_cy = '0;
         end
         set_flags = ($urandom % 3) != 0;
         add_nop   = ($urandom % 4) == 0;
         add_wcond = 3'($urandom);
         mul_wcond = 3'($urandom);
         br_cond   = 4'($urandom);
         run_cycle((k % 2) ? "R6" : "R8", 1'b1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule